// File: doc/BRIEF.md
# BCD Adjust Unit

This block applies the decimal corrections that follow a byte-wide add or subtract on a 16-bit accumulator made of a high byte and a low byte. It supports three corrections: the unpacked (ASCII) adjust after an add, the unpacked adjust after a subtract, and the packed decimal adjust after a subtract. Its inputs are the accumulator, the auxiliary-carry and carry flags left by the previous arithmetic step, and an operation select. It returns the corrected accumulator and six status flags: carry, parity, auxiliary carry, zero, sign and overflow.

Every flag has a defined value, including the ones that are usually left undefined for these corrections. Sign, overflow and zero depend on range tests on the incoming low byte and on which correction branch is taken. The correction itself is combinational. The result and flags are captured in an output register on the next rising clock edge. The select works as a small state choice: `OP_ASC_ADD` (2'b00), `OP_ASC_SUB` (2'b01), `OP_DEC_SUB` (2'b10) and `OP_HOLD` (2'b11). From any of the three operation selects, the next edge loads a new result. From `OP_HOLD`, the next edge keeps the registered result as it is.

Top module: `bcd_adjust_unit`

## Requirements
- R1: While rst_n is low, acc_o is 0x0000 and all six flag outputs are 0.
- R2: With op_i = 2'b11 (hold), a clock edge leaves acc_o and every flag output unchanged, whatever acc_i, af_i and cf_i are.
- R3: A result for the inputs present at a rising edge appears on the outputs just after that edge, and not before it.
- R4: Unpacked add adjust (op_i = 2'b00) with low nibble of the low byte above 9: the accumulator gains 0x106, cf and af are 1, of is 1 exactly when the input low byte's upper nibble is 7, and zf is 1 when the low byte after the addition is 0.
- R5: Unpacked add adjust with low nibble 9 or less and af_i = 1: the accumulator gains 0x106, cf and af are 1, and of and zf are 0.
- R6: Unpacked add adjust with low nibble 9 or less and af_i = 0: the accumulator is unchanged before masking, cf, af and of are 0, and zf is 1 when the low byte is 0.
- R7: For unpacked add adjust, sf is 1 exactly when the input low byte lies in 0x7A..0xF9.
- R8: Unpacked subtract adjust (op_i = 2'b01) with low nibble above 9: the accumulator loses 0x106, cf and af are 1, of is 0, and sf is 1 when the input low byte exceeds 0x85.
- R9: Unpacked subtract adjust with low nibble 9 or less and af_i = 1: the accumulator loses 0x106, cf and af are 1, of is 1 for an input low byte in 0x80..0x85, and sf is 1 for an input below 0x06 or above 0x85.
- R10: Unpacked subtract adjust with low nibble 9 or less and af_i = 0: the accumulator is unchanged before masking, sf is the input bit 7, and of, cf and af are 0.
- R11: For both unpacked adjusts, zf and pf come from the low byte after the add or subtract and before masking. pf is 1 when that byte has an even number of set bits. The output low byte is then reduced to its low 4 bits.
- R12: Packed subtract adjust (op_i = 2'b10) when the low nibble exceeds 9 or af_i = 1: if the byte exceeds 0x99 or cf_i = 1, the byte loses 0x60 and cf is 1; otherwise cf is 1 only for a byte of 0x05 or below. The byte then loses 6 and af is 1.
- R13: Packed subtract adjust when the low nibble is 9 or less and af_i = 0: a byte above 0x99 or cf_i = 1 subtracts 0x60 and sets cf; otherwise cf is 0. af is 0, and the high byte passes through unchanged in every packed case.
- R14: For packed subtract adjust, of is 1 when the input byte had bit 7 set and the final byte has bit 7 clear. sf, zf and pf (even parity) come from the final byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; results are captured on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Operation select: 00 unpacked add adjust, 01 unpacked subtract adjust, 10 packed subtract adjust, 11 hold |
| acc_i | input | 16 | Accumulator, high byte in bits 15:8 |
| af_i | input | 1 | Incoming auxiliary carry |
| cf_i | input | 1 | Incoming carry |
| acc_o | output | 16 | Adjusted accumulator |
| cf_o | output | 1 | Carry flag |
| pf_o | output | 1 | Parity flag (1 = even count of set bits) |
| af_o | output | 1 | Auxiliary carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |

## Verification
Every result and every flag is due one rising edge after its inputs are applied. The bench changes inputs on a falling edge and compares outputs on the next falling edge, after exactly one capture. A few vectors also sample just before the capturing edge, to confirm that the previous result is still shown there. Hold cycles are checked one edge after the hold is applied, against the value registered before it.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

    typedef enum logic [1:0] {
        OP_ASC_ADD = 2'b00,
        OP_ASC_SUB = 2'b01,
        OP_DEC_SUB = 2'b10,
        OP_HOLD    = 2'b11
    } adj_op_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } adj_flags_s;

endpackage

// File: rtl/bcd_ascii_add.sv
module bcd_ascii_add
    import bcd_adj_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic             af_i,
    output logic [ACC_W-1:0] acc_n,
    output adj_flags_s       flg_n
);
    localparam int BYTE_W = ACC_W / 2;
    localparam logic [ACC_W-1:0] STEP = ACC_W'((1 << BYTE_W) + 6);

    logic [BYTE_W-1:0] lo;
    logic [ACC_W-1:0]  sum;
    logic [ACC_W-1:0]  nxt;

    assign lo  = acc_i[BYTE_W-1:0];
    assign sum = acc_i + STEP;

    always_comb begin
        flg_n    = '0;
        nxt      = acc_i;
        flg_n.sf = (lo >= BYTE_W'(8'h7A)) && (lo <= BYTE_W'(8'hF9));
        if (lo[3:0] > 4'd9) begin
            nxt      = sum;
            flg_n.cf = 1'b1;
            flg_n.af = 1'b1;
            flg_n.of = (lo[7:4] == 4'h7);
            flg_n.zf = (sum[BYTE_W-1:0] == '0);
            flg_n.pf = ~^sum[BYTE_W-1:0];
        end else if (af_i) begin
            nxt      = sum;
            flg_n.cf = 1'b1;
            flg_n.af = 1'b1;
            flg_n.pf = ~^sum[BYTE_W-1:0];
        end else begin
            flg_n.zf = (lo == '0);
            flg_n.pf = ~^lo;
        end
        acc_n = {nxt[ACC_W-1:BYTE_W], {(BYTE_W-4){1'b0}}, nxt[3:0]};
    end

endmodule

// File: rtl/bcd_ascii_sub.sv
module bcd_ascii_sub
    import bcd_adj_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic             af_i,
    output logic [ACC_W-1:0] acc_n,
    output adj_flags_s       flg_n
);
    localparam int BYTE_W = ACC_W / 2;
    localparam logic [ACC_W-1:0] STEP = ACC_W'((1 << BYTE_W) + 6);

    logic [BYTE_W-1:0] lo;
    logic [ACC_W-1:0]  diff;
    logic [ACC_W-1:0]  nxt;

    assign lo   = acc_i[BYTE_W-1:0];
    assign diff = acc_i - STEP;

    always_comb begin
        flg_n = '0;
        nxt   = acc_i;
        if (lo[3:0] > 4'd9) begin
            nxt      = diff;
            flg_n.sf = (lo > BYTE_W'(8'h85));
            flg_n.cf = 1'b1;
            flg_n.af = 1'b1;
        end else if (af_i) begin
            nxt      = diff;
            flg_n.of = (lo >= BYTE_W'(8'h80)) && (lo <= BYTE_W'(8'h85));
            flg_n.sf = (lo < BYTE_W'(8'h06)) || (lo > BYTE_W'(8'h85));
            flg_n.cf = 1'b1;
            flg_n.af = 1'b1;
        end else begin
            flg_n.sf = lo[BYTE_W-1];
        end
        flg_n.zf = (nxt[BYTE_W-1:0] == '0);
        flg_n.pf = ~^nxt[BYTE_W-1:0];
        acc_n    = {nxt[ACC_W-1:BYTE_W], {(BYTE_W-4){1'b0}}, nxt[3:0]};
    end

endmodule

// File: rtl/bcd_dec_sub.sv
module bcd_dec_sub
    import bcd_adj_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic             af_i,
    input  logic             cf_i,
    output logic [ACC_W-1:0] acc_n,
    output adj_flags_s       flg_n
);
    localparam int BYTE_W = ACC_W / 2;

    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] mid;
    logic [BYTE_W-1:0] fin;
    logic              nib_adj;
    logic              big;

    assign lo      = acc_i[BYTE_W-1:0];
    assign nib_adj = (lo[3:0] > 4'd9) || af_i;
    assign big     = (lo > BYTE_W'(8'h99)) || cf_i;

    always_comb begin
        flg_n = '0;
        mid   = big ? (lo - BYTE_W'(8'h60)) : lo;
        fin   = nib_adj ? (mid - BYTE_W'(6)) : mid;
        if (big)          flg_n.cf = 1'b1;
        else if (nib_adj) flg_n.cf = (lo <= BYTE_W'(8'h05));
        else              flg_n.cf = 1'b0;
        flg_n.af = nib_adj;
        flg_n.of = lo[BYTE_W-1] & ~fin[BYTE_W-1];
        flg_n.sf = fin[BYTE_W-1];
        flg_n.zf = (fin == '0);
        flg_n.pf = ~^fin;
        acc_n    = {acc_i[ACC_W-1:BYTE_W], fin};
    end

endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
    import bcd_adj_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       op_i,
    input  logic [ACC_W-1:0] acc_i,
    input  logic             af_i,
    input  logic             cf_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             cf_o,
    output logic             pf_o,
    output logic             af_o,
    output logic             zf_o,
    output logic             sf_o,
    output logic             of_o
);
    localparam int BYTE_W = ACC_W / 2;

    adj_op_e          op_sel;
    logic [ACC_W-1:0] add_acc, sub_acc, dec_acc, acc_d, acc_q;
    adj_flags_s       add_flg, sub_flg, dec_flg, flg_d, flg_q;

    assign op_sel = adj_op_e'(op_i);

    bcd_ascii_add #(.ACC_W(ACC_W)) u_add (
        .acc_i(acc_i), .af_i(af_i), .acc_n(add_acc), .flg_n(add_flg)
    );

    bcd_ascii_sub #(.ACC_W(ACC_W)) u_sub (
        .acc_i(acc_i), .af_i(af_i), .acc_n(sub_acc), .flg_n(sub_flg)
    );

    bcd_dec_sub #(.ACC_W(ACC_W)) u_dec (
        .acc_i(acc_i), .af_i(af_i), .cf_i(cf_i), .acc_n(dec_acc), .flg_n(dec_flg)
    );

    always_comb begin
        unique case (op_sel)
            OP_ASC_ADD: begin acc_d = add_acc; flg_d = add_flg; end
            OP_ASC_SUB: begin acc_d = sub_acc; flg_d = sub_flg; end
            OP_DEC_SUB: begin acc_d = dec_acc; flg_d = dec_flg; end
            OP_HOLD:    begin acc_d = acc_q;   flg_d = flg_q;   end
            default:    begin acc_d = acc_q;   flg_d = flg_q;   end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            flg_q <= '0;
        end else begin
            acc_q <= acc_d;
            flg_q <= flg_d;
        end
    end

    always_comb begin
        acc_o = acc_q;
        cf_o  = flg_q.cf;
        pf_o  = flg_q.pf;
        af_o  = flg_q.af;
        zf_o  = flg_q.zf;
        sf_o  = flg_q.sf;
        of_o  = flg_q.of;
    end

    // R2
    hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b11) |=> ($stable(acc_o) && $stable({cf_o, pf_o, af_o, zf_o, sf_o, of_o})));

    // R11
    ascii_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b00 || op_i == 2'b01) |=> (acc_o[BYTE_W-1:4] == '0));

    // R4
    ascii_cf_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b00 || op_i == 2'b01) |=> (cf_o == af_o));

    // R13
    dec_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b10) |=> (acc_o[ACC_W-1:BYTE_W] == $past(acc_i[ACC_W-1:BYTE_W])));

    // R14
    dec_of_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b10) |=> !(of_o && sf_o) && !(zf_o && sf_o));

endmodule

// File: tb/test_bcd_adjust_unit.sv
`timescale 1ns/1ps
module test_bcd_adjust_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_i = 2'b11;
    logic [15:0] acc_i = '0;
    logic        af_i = 1'b0;
    logic        cf_i = 1'b0;
    logic [15:0] acc_o;
    logic        cf_o, pf_o, af_o, zf_o, sf_o, of_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int e_acc, e_cf, e_pf, e_af, e_zf, e_sf, e_of;
    string e_tag;

    always #4 clk = ~clk;

    bcd_adjust_unit i_bcd_adjust_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i), .af_i(af_i), .cf_i(cf_i),
        .acc_o(acc_o), .cf_o(cf_o), .pf_o(pf_o), .af_o(af_o), .zf_o(zf_o),
        .sf_o(sf_o), .of_o(of_o)
    );

    function automatic int parity_even(input int b);
        int c = 0;
        for (int k = 0; k < 8; k++) c += (b >> k) & 1;
        return (c % 2 == 0) ? 1 : 0;
    endfunction

    // behavioural reference: fills the e_* expectations from the requirements
    task automatic model(input int op, input int acc, input int af, input int cf);
        int ah = acc / 256;
        int al = acc % 256;
        int t;
        int pre;
        int x;
        e_cf = 0; e_pf = 0; e_af = 0; e_zf = 0; e_sf = 0; e_of = 0;
        if (op == 0) begin
            e_sf = (al >= 122 && al <= 249) ? 1 : 0;              // R7
            if (al % 16 > 9) begin                                 // R4
                t = (acc + 262) % 65536; pre = t % 256;
                e_cf = 1; e_af = 1; e_of = (al / 16 == 7) ? 1 : 0;
                e_zf = (pre == 0) ? 1 : 0; e_tag = "R4";
            end else if (af != 0) begin                            // R5
                t = (acc + 262) % 65536; pre = t % 256;
                e_cf = 1; e_af = 1; e_tag = "R5";
            end else begin                                         // R6
                t = acc; pre = al; e_zf = (al == 0) ? 1 : 0; e_tag = "R6";
            end
            e_pf = parity_even(pre);                               // R11
            e_acc = (t / 256) * 256 + (pre % 16);
        end else if (op == 1) begin
            if (al % 16 > 9) begin                                 // R8
                t = (acc - 262 + 65536) % 65536;
                e_sf = (al > 133) ? 1 : 0; e_cf = 1; e_af = 1; e_tag = "R8";
            end else if (af != 0) begin                            // R9
                t = (acc - 262 + 65536) % 65536;
                e_of = (al >= 128 && al <= 133) ? 1 : 0;
                e_sf = (al < 6 || al > 133) ? 1 : 0;
                e_cf = 1; e_af = 1; e_tag = "R9";
            end else begin                                         // R10
                t = acc; e_sf = (al >= 128) ? 1 : 0; e_tag = "R10";
            end
            pre = t % 256;
            e_zf = (pre == 0) ? 1 : 0;                             // R11
            e_pf = parity_even(pre);
            e_acc = (t / 256) * 256 + (pre % 16);
        end else begin
            x = al;
            if (al % 16 > 9 || af != 0) begin                      // R12
                if (al > 153 || cf != 0) begin x -= 96; e_cf = 1; end
                else e_cf = (al <= 5) ? 1 : 0;
                x -= 6; e_af = 1; e_tag = "R12";
            end else begin                                         // R13
                if (al > 153 || cf != 0) begin x -= 96; e_cf = 1; end
                e_tag = "R13";
            end
            x = (x + 512) % 256;
            e_of = (al >= 128 && x < 128) ? 1 : 0;                 // R14
            e_sf = (x >= 128) ? 1 : 0;
            e_zf = (x == 0) ? 1 : 0;
            e_pf = parity_even(x);
            e_acc = ah * 256 + x;
        end
    endtask

    task automatic compare(input string tag);
        n_chk++;
        if (acc_o !== 16'(e_acc) || cf_o !== 1'(e_cf) || pf_o !== 1'(e_pf) || af_o !== 1'(e_af) ||
            zf_o !== 1'(e_zf) || sf_o !== 1'(e_sf) || of_o !== 1'(e_of)) begin
            n_fail++;
            $display("FAIL %s: acc=%h c%0d p%0d a%0d z%0d s%0d o%0d, expected acc=%h c%0d p%0d a%0d z%0d s%0d o%0d",
                     tag, acc_o, cf_o, pf_o, af_o, zf_o, sf_o, of_o,
                     16'(e_acc), e_cf, e_pf, e_af, e_zf, e_sf, e_of);
        end
    endtask

    task automatic apply(input int op, input int acc, input int af, input int cf, input bit early);
        @(negedge clk);
        op_i = 2'(op); acc_i = 16'(acc); af_i = 1'(af); cf_i = 1'(cf);
        if (early) begin
            #3;
            compare("R3 before edge");   // old result still shown
        end
        model(op, acc, af, cf);
        @(negedge clk);
        compare(e_tag);
    endtask

    initial begin
        e_acc = 0; e_cf = 0; e_pf = 0; e_af = 0; e_zf = 0; e_sf = 0; e_of = 0;
        repeat (3) @(negedge clk);
        compare("R1 reset");
        acc_i = 16'hFFFF; af_i = 1'b1; cf_i = 1'b1; op_i = 2'b00;
        @(negedge clk);
        compare("R1 reset held");
        rst_n = 1'b1;

        for (int op = 0; op < 3; op++) begin
            for (int fc = 0; fc < 4; fc++) begin
                for (int al = 0; al < 256; al++) begin
                    int ah = (al * 7 + fc * 61 + op * 17) % 256;
                    if (al % 64 == 5) ah = 255;
                    apply(op, ah * 256 + al, fc / 2, fc % 2, (al % 97 == 3));
                end
            end
        end

        // directed corners
        apply(0, 16'h00FA, 0, 0, 0);   // R4 carry into high byte, zero low byte
        apply(0, 16'h017A, 0, 0, 0);   // R4 overflow, sign
        apply(1, 16'h0005, 1, 0, 0);   // R9 low byte borrow, sign
        apply(1, 16'h0085, 1, 0, 0);   // R9 overflow
        apply(2, 16'h1205, 1, 0, 0);   // R12 cf from small byte
        apply(2, 16'h3480, 0, 1, 0);   // R13 of set, high byte kept

        // hold behaviour
        for (int h = 0; h < 6; h++) begin
            apply(h % 3, 16'h1234 + h * 16'h1111, h % 2, (h / 2) % 2, 0);
            @(negedge clk);
            op_i = 2'b11; acc_i = 16'hA5C3 ^ 16'(h); af_i = ~af_i; cf_i = ~cf_i;
            @(negedge clk);
            compare("R2 hold");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule